// File: doc/BRIEF.md
# ULPI Link-Side PHY Register Access Engine

This block sits on the link side of an 8-bit ULPI bus and carries out single register reads and writes in the PHY. A client presents a request as a direction flag, an 8-bit register address and a write byte. The engine turns it into the bus sequence: a command byte, an optional address byte and, for a write, a data byte with a stop strobe. For a read, the PHY turns the bus around and returns one byte. When the operation finishes, a one-cycle completion pulse comes back, and the read byte comes with it for a read.

The addressing form is picked from the address. Low addresses fit into the command byte itself. Every other address uses an escape code in the command byte and sends the full address in the next byte. The PHY owns the bus whenever it raises its direction line. If it does that while the engine is still sending, the operation is abandoned. The engine waits for the bus to come back and then sends the same operation again from its first byte, as many times as needed. The client sees none of this.

The data pins are split into an output byte, an output enable and an input byte, so the pad tri-state sits outside the block.

Top module: `ulpi_reg_engine`

## Requirements
- R1: For an address not above IMM_LAST (default 0x2E), the first byte sent is bit7=1, bit6=0 for a write or 1 for a read, and bits 5:0 equal to the address bits 5:0. No separate address byte follows.
- R2: For an address above IMM_LAST, the first byte carries bit7=1, bit6 as in R1 and bits 5:0 = 6'b101111. The next byte sent is the full 8-bit address.
- R3: Each outgoing byte (command, address, write data) stays unchanged on the output byte until a cycle in which NXT is sampled high. The next byte appears in the following cycle.
- R4: Once a write's data byte has been accepted, STP is high for exactly one cycle while the output byte is 0x00. The completion pulse follows in the next cycle.
- R5: For a read whose last command byte has been accepted, the first cycle in which DIR is sampled high is a turnaround cycle. The input byte is captured in the second DIR-high cycle. The completion pulse rises in the cycle after DIR is sampled low again, and the read data output then holds the captured byte.
- R6: If DIR is sampled high while a command, address, data or stop byte is being sent, the operation is abandoned without a completion pulse. The engine waits until DIR is low and then sends the same operation again from its command byte.
- R7: The output enable is high exactly when DIR is low. When the engine has nothing to send, the output byte is 0x00.
- R8: The request-ready output is high only when the engine is idle. A request is taken when valid and ready are both high. The completion pulse lasts one cycle and stays low until the operation has finished.
- R9: After reset the engine is idle and ready, STP and the completion pulse are low, and the output byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ULPI interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | PHY register address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Engine idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| ulpi_dir | input | 1 | PHY owns the bus when high |
| ulpi_nxt | input | 1 | PHY accepted the current byte |
| ulpi_stp | output | 1 | Stop strobe ending a write |
| ulpi_data_i | input | 8 | Bus byte from the PHY |
| ulpi_data_o | output | 8 | Bus byte to the PHY |
| ulpi_data_oe | output | 1 | Output enable for the data pads |

## Verification
The bench builds the engine with its default IMM_LAST of 0x2E. It sweeps all 256 addresses for both writes and reads, so both sides of the boundary between 0x2E and 0x2F are covered, along with the escape code's own address value. A bench PHY model adds zero to two cycles of NXT latency per byte. On a regular schedule it also raises DIR in the middle of the command, address or data byte, which exercises the retry from every byte position of both addressing forms.

// File: rtl/ulpi_reg_engine.sv
module ulpi_reg_engine #(
  parameter logic [7:0] IMM_LAST = 8'h2E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       req_ready,
  output logic       done,
  output logic [7:0] rdata,
  input  logic       ulpi_dir,
  input  logic       ulpi_nxt,
  output logic       ulpi_stp,
  input  logic [7:0] ulpi_data_i,
  output logic [7:0] ulpi_data_o,
  output logic       ulpi_data_oe
);
  localparam logic [5:0] EXT_CODE = 6'b101111;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADDR, S_WDAT, S_STP, S_RDIR, S_RCAP, S_RWAIT, S_ABRT
  } state_t;

  state_t     st;
  logic       op_wr;
  logic [7:0] op_addr;
  logic [7:0] op_wdata;
  logic       ext;
  logic [7:0] cmd_byte;
  logic       tx_phase;

  assign ext      = op_addr > IMM_LAST;
  assign cmd_byte = {1'b1, ~op_wr, ext ? EXT_CODE : op_addr[5:0]};
  assign tx_phase = (st == S_CMD) || (st == S_ADDR) || (st == S_WDAT);

  assign req_ready    = (st == S_IDLE);
  assign ulpi_stp     = (st == S_STP);
  assign ulpi_data_oe = ~ulpi_dir;

  always_comb begin
    case (st)
      S_CMD:   ulpi_data_o = cmd_byte;
      S_ADDR:  ulpi_data_o = op_addr;
      S_WDAT:  ulpi_data_o = op_wdata;
      default: ulpi_data_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_wr    <= 1'b0;
      op_addr  <= 8'h00;
      op_wdata <= 8'h00;
      rdata    <= 8'h00;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (req_valid) begin
            op_wr    <= req_write;
            op_addr  <= req_addr;
            op_wdata <= req_wdata;
            st       <= S_CMD;
          end
        S_CMD:
          if (ulpi_dir)      st <= S_ABRT;
          else if (ulpi_nxt) st <= ext ? S_ADDR : (op_wr ? S_WDAT : S_RDIR);
        S_ADDR:
          if (ulpi_dir)      st <= S_ABRT;
          else if (ulpi_nxt) st <= op_wr ? S_WDAT : S_RDIR;
        S_WDAT:
          if (ulpi_dir)      st <= S_ABRT;
          else if (ulpi_nxt) st <= S_STP;
        S_STP:
          if (ulpi_dir) st <= S_ABRT;
          else begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        S_RDIR:
          if (ulpi_dir) st <= S_RCAP;
        S_RCAP:
          if (!ulpi_dir) st <= S_CMD;
          else begin
            rdata <= ulpi_data_i;
            st    <= S_RWAIT;
          end
        S_RWAIT:
          if (!ulpi_dir) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        S_ABRT:
          if (!ulpi_dir) st <= S_CMD;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ulpi_reg_engine_chk.sv
module ulpi_reg_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [7:0] req_addr,
  input logic       done,
  input logic       ulpi_dir,
  input logic       ulpi_nxt,
  input logic       ulpi_stp,
  input logic [7:0] ulpi_data_o,
  input logic       tx_phase
);
  a_r3_hold_until_nxt: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_phase && !ulpi_nxt && !ulpi_dir) |=> (tx_phase && $stable(ulpi_data_o)));

  a_r4_stp_single: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |=> !ulpi_stp);

  a_r4_done_after_stp: assert property (@(posedge clk) disable iff (!rst_n)
    (ulpi_stp && !ulpi_dir) |=> done);

  a_r6_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_phase && ulpi_dir) |=> (!tx_phase && !done));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  a_r1_imm_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr <= 8'h2E) |=>
      (tx_phase && ulpi_data_o[5:0] == $past(req_addr[5:0])));
endmodule

bind ulpi_reg_engine ulpi_reg_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .done(done), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
  .ulpi_stp(ulpi_stp), .ulpi_data_o(ulpi_data_o), .tx_phase(tx_phase)
);

// File: tb/ulpi_reg_engine_test.sv
`timescale 1ns/1ps
module ulpi_reg_engine_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = 8'h00, req_wdata = 8'h00;
  logic       req_ready, done, ulpi_stp, ulpi_data_oe;
  logic [7:0] rdata, ulpi_data_o;
  logic       ulpi_dir = 1'b0, ulpi_nxt = 1'b0;
  logic [7:0] ulpi_data_i = 8'h00;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  ulpi_reg_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rdata(rdata), .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
    .ulpi_stp(ulpi_stp), .ulpi_data_i(ulpi_data_i), .ulpi_data_o(ulpi_data_o),
    .ulpi_data_oe(ulpi_data_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [7:0] a, input logic [7:0] wd,
                       input int lat, input int ab);
    logic [7:0] bytes [3];
    int n, i;
    bit ext, aborted;
    logic [7:0] rv;
    ext = a > 8'h2E;
    bytes[0] = {1'b1, ~wr, ext ? 6'b101111 : a[5:0]};
    n = 1;
    if (ext) begin bytes[n] = a; n++; end
    if (wr)  begin bytes[n] = wd; n++; end
    rv = a ^ 8'hA5;
    chk(req_ready == 1'b1, "R8 ready idle", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~wd;
    i = 0; aborted = 1'b0;
    while (i < n) begin
      if (!aborted && ab == i) begin
        ulpi_dir = 1'b1; ulpi_nxt = 1'b0; aborted = 1'b1;
        repeat (2) begin
          @(negedge clk);
          chk(ulpi_data_oe == 1'b0, "R7 release on dir", ulpi_data_oe, 0);
          chk(done == 1'b0, "R6 no done on abort", done, 0);
        end
        @(negedge clk); ulpi_dir = 1'b0;
        @(negedge clk); i = 0;
      end else begin
        for (int w = 0; w <= lat; w++) begin
          chk(ulpi_data_oe && ulpi_data_o == bytes[i],
              i == 0 ? (ext ? "R2 ext cmd" : "R1 imm cmd") : (ext && i == 1 ? "R2 addr byte" : "R3 data byte"),
              ulpi_data_o, bytes[i]);
          chk(req_ready == 1'b0 && done == 1'b0, "R8 busy", {req_ready, done}, 0);
          ulpi_nxt = (w == lat);
          @(negedge clk);
        end
        ulpi_nxt = 1'b0; i++;
      end
    end
    if (wr) begin
      chk(ulpi_stp == 1'b1 && ulpi_data_o == 8'h00 && done == 1'b0, "R4 stp",
          {ulpi_stp, ulpi_data_o}, 9'h100);
      @(negedge clk);
      chk(done == 1'b1 && ulpi_stp == 1'b0, "R4 done after stp", {done, ulpi_stp}, 2'b10);
    end else begin
      chk(ulpi_stp == 1'b0 && ulpi_data_oe == 1'b1 && ulpi_data_o == 8'h00, "R7 idle byte",
          ulpi_data_o, 0);
      ulpi_dir = 1'b1;
      @(negedge clk);
      chk(ulpi_data_oe == 1'b0, "R7 oe low in turnaround", ulpi_data_oe, 0);
      ulpi_data_i = rv;
      @(negedge clk);
      ulpi_dir = 1'b0; ulpi_data_i = 8'h00;
      chk(done == 1'b0, "R5 no early done", done, 0);
      @(negedge clk);
      chk(done == 1'b1 && rdata == rv, "R5 read data", rdata, rv);
    end
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && ulpi_stp == 1'b0 && ulpi_data_o == 8'h00,
        "R9 reset state", {req_ready, done, ulpi_stp, ulpi_data_o}, 11'h400);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && ulpi_data_oe == 1'b1, "R9 idle after reset", req_ready, 1);
    for (int a = 0; a < 256; a++) begin
      int nb, ab;
      nb = 1 + (a > 8'h2E ? 1 : 0) + 1;
      ab = (a % 4 == 3) ? (a / 4) % nb : -1;
      do_op(1'b1, 8'(a), 8'(a * 7 + 3), a % 3, ab);
    end
    for (int a = 0; a < 256; a++) begin
      int nb, ab;
      nb = 1 + (a > 8'h2E ? 1 : 0);
      ab = (a % 4 == 1) ? (a / 4) % nb : -1;
      do_op(1'b0, 8'(a), 8'h00, (a + 1) % 3, ab);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule